// File: doc/BRIEF.md
# Multi-cycle integer processor core

This block is a compact multi-cycle processor that executes a reduced 32-bit load/store instruction set. Each instruction walks through five phases in a fixed order: fetch, decode, operand fetch, execute and store. A phase may stretch over several clock cycles while the core waits for memory. Instructions and data share one word-wide memory port. That port uses a request/ready handshake, and memory is byte-addressed and big-endian.

The core holds thirty-two 32-bit general registers. Register zero always reads as zero. The core runs integer add, subtract, and, or, xor, logical left shift and logical right shift, plus word loads and word stores. The second operand is either a register or a sign-extended 13-bit constant. An instruction the core does not implement raises an illegal-instruction flag and halts the core. A word access whose address is not a multiple of four raises a misalignment flag and halts the core without touching memory or registers. A halted core stays halted until reset.

Top module: `mcc_core`

## Requirements
- R1: With a memory that answers in the same cycle, an arithmetic instruction takes exactly five clock cycles, one per phase. The next fetch is accepted five cycles after the previous one.
- R2: After reset the first fetch reads address RESET_PC (default 0). Each accepted fetch advances the program counter by 4.
- R3: The register file has 32 registers of 32 bits. Register 0 reads as zero, and any write to it is discarded.
- R4: The instruction fields are: format in bits 31:30, destination in 29:25, operation code in 24:19, first source in 18:14, and constant-select in bit 13. With bit 13 at 0, the second source is bits 4:0 and bits 12:5 are ignored. Format 2 means arithmetic or logic; format 3 means memory.
- R5: With bit 13 at 1, bits 12:0 are sign-extended to form the second operand, giving a range of -4096 to +4095. The word 0x94066168 adds 360 to register 25 and writes the sum to register 10.
- R6: Format-2 operation codes are: add 0x00, and 0x01, or 0x02, xor 0x03, sub 0x04, sll 0x25, srl 0x26. Shifts use only the low 5 bits of the second operand.
- R7: Format-3 operation code 0x00 loads a word and 0x04 stores the destination register. The address is the first source plus either the second source register or the sign-extended constant.
- R8: Memory is big-endian: the byte at address A is bits 31:24 of the word at A.
- R9: A memory request keeps its address, direction and data unchanged until ready is seen. The core stays in its phase while it waits.
- R10: Any format other than 2 or 3, or any operation code not listed for its format, sets `illegal` and halts the core.
- R11: A load or store whose address has bits 1:0 not zero sets `misaligned` and halts the core. No memory access is made for that instruction.
- R12: During and just after reset, all flags are low and the core is requesting a fetch.
- R13: Once halted, the core makes no further memory requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address, word aligned |
| mem_wdata | output | 32 | Store data, big-endian word |
| mem_rdata | input | 32 | Read data, big-endian word |
| mem_ready | input | 1 | Memory accepts/answers the request this cycle |
| halted | output | 1 | Core has stopped |
| illegal | output | 1 | Stopped on an unimplemented instruction |
| misaligned | output | 1 | Stopped on an unaligned word access |

## Verification
A wrong operand or result register shows up as a wrong word in the store that follows the faulty instruction. That store lands at most two instructions later, so the error is visible on the port within about ten cycles. A broken phase counter or program counter moves the cycle stamps and addresses of accepted fetches, which appear on the port at the very next fetch. A bad halt decision shows up as an extra or missing memory request, or as the wrong flag right after the offending instruction's decode or execute phase.

// File: rtl/mcc_pkg.sv
package mcc_pkg;

   localparam logic [1:0] FMT_ALU = 2'd2;
   localparam logic [1:0] FMT_MEM = 2'd3;

   localparam logic [5:0] OP_ADD = 6'h00;
   localparam logic [5:0] OP_AND = 6'h01;
   localparam logic [5:0] OP_OR  = 6'h02;
   localparam logic [5:0] OP_XOR = 6'h03;
   localparam logic [5:0] OP_SUB = 6'h04;
   localparam logic [5:0] OP_SLL = 6'h25;
   localparam logic [5:0] OP_SRL = 6'h26;
   localparam logic [5:0] OP_LDW = 6'h00;
   localparam logic [5:0] OP_STW = 6'h04;

   typedef enum logic [2:0] {
      ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_SLL, ALU_SRL
   } alu_op_t;

   typedef enum logic [2:0] {
      PH_FETCH, PH_DECODE, PH_OPER, PH_EXEC, PH_STORE, PH_HALT
   } phase_t;

   typedef struct packed {
      logic [4:0] rd;
      logic [4:0] rs1;
      logic [4:0] rs2;
      logic       use_imm;
      logic       is_alu;
      logic       is_load;
      logic       is_store;
      logic       legal;
      alu_op_t    op;
   } dec_t;

endpackage

// File: rtl/mcc_regfile.sv
module mcc_regfile #(
   parameter int XLEN = 32,
   parameter int NREG = 32,
   localparam int RW  = $clog2(NREG)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [RW-1:0]   raddr_a,
   input  logic [RW-1:0]   raddr_b,
   output logic [XLEN-1:0] rdata_a,
   output logic [XLEN-1:0] rdata_b,
   input  logic            we,
   input  logic [RW-1:0]   waddr,
   input  logic [XLEN-1:0] wdata
);

   logic [XLEN-1:0] regs [NREG];

   for (genvar i = 0; i < NREG; i++) begin : g_reg
      if (i == 0) begin : g_zero
         assign regs[i] = '0;
      end else begin : g_flop
         logic [XLEN-1:0] q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               q <= '0;
            else if (we && waddr == RW'(i))
               q <= wdata;
         end
         assign regs[i] = q;
      end
   end

   assign rdata_a = regs[raddr_a];
   assign rdata_b = regs[raddr_b];

endmodule

// File: rtl/mcc_decode.sv
module mcc_decode
   import mcc_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic [31:0]     instr,
   output dec_t            dec,
   output logic [XLEN-1:0] imm
);

   logic [1:0] fmt;
   logic [5:0] op3;

   assign fmt = instr[31:30];
   assign op3 = instr[24:19];
   assign imm = {{(XLEN-13){instr[12]}}, instr[12:0]};

   always_comb begin
      dec          = '0;
      dec.rd       = instr[29:25];
      dec.rs1      = instr[18:14];
      dec.rs2      = instr[4:0];
      dec.use_imm  = instr[13];
      dec.op       = ALU_ADD;
      if (fmt == FMT_ALU) begin
         dec.is_alu = 1'b1;
         dec.legal  = 1'b1;
         case (op3)
            OP_ADD:  dec.op = ALU_ADD;
            OP_SUB:  dec.op = ALU_SUB;
            OP_AND:  dec.op = ALU_AND;
            OP_OR:   dec.op = ALU_OR;
            OP_XOR:  dec.op = ALU_XOR;
            OP_SLL:  dec.op = ALU_SLL;
            OP_SRL:  dec.op = ALU_SRL;
            default: begin
               dec.legal  = 1'b0;
               dec.is_alu = 1'b0;
            end
         endcase
      end else if (fmt == FMT_MEM) begin
         dec.is_load  = (op3 == OP_LDW);
         dec.is_store = (op3 == OP_STW);
         dec.legal    = dec.is_load || dec.is_store;
      end
      AST_DEC_ONE_KIND: assert ($onehot0({dec.is_alu, dec.is_load, dec.is_store})); // R4
   end

endmodule

// File: rtl/mcc_alu.sv
module mcc_alu
   import mcc_pkg::*;
#(
   parameter int XLEN = 32,
   localparam int SW  = $clog2(XLEN)
) (
   input  alu_op_t         op,
   input  logic [XLEN-1:0] a,
   input  logic [XLEN-1:0] b,
   output logic [XLEN-1:0] y
);

   logic [SW-1:0] shamt;
   assign shamt = b[SW-1:0];

   always_comb begin
      case (op)
         ALU_ADD: y = a + b;
         ALU_SUB: y = a - b;
         ALU_AND: y = a & b;
         ALU_OR:  y = a | b;
         ALU_XOR: y = a ^ b;
         ALU_SLL: y = a << shamt;
         ALU_SRL: y = a >> shamt;
         default: y = a + b;
      endcase
   end

endmodule

// File: rtl/mcc_core.sv
module mcc_core
   import mcc_pkg::*;
#(
   parameter int          XLEN     = 32,
   parameter int          NREG     = 32,
   parameter logic [31:0] RESET_PC = 32'h0000_0000,
   localparam int         RW       = $clog2(NREG)
) (
   input  logic            clk,
   input  logic            rst_n,
   output logic            mem_req,
   output logic            mem_we,
   output logic [31:0]     mem_addr,
   output logic [XLEN-1:0] mem_wdata,
   input  logic [XLEN-1:0] mem_rdata,
   input  logic            mem_ready,
   output logic            halted,
   output logic            illegal,
   output logic            misaligned
);

   if (XLEN != 32) begin : g_bad_xlen
      $error("mcc_core: the instruction layout needs XLEN of 32");
   end
   if (NREG != 32) begin : g_bad_nreg
      $error("mcc_core: register fields are 5 bits, NREG must be 32");
   end
   if (RESET_PC[1:0] != 2'b00) begin : g_bad_pc
      $error("mcc_core: RESET_PC must be word aligned");
   end

   phase_t          phase_q;
   logic [31:0]     pc_q;
   logic [31:0]     ir_q;
   logic [XLEN-1:0] opa_q, opb_q, res_q, sdata_q;
   logic            illegal_q, misaligned_q;

   dec_t            dec;
   logic [XLEN-1:0] imm;
   logic [XLEN-1:0] alu_y;
   logic [RW-1:0]   raddr_b;
   logic [XLEN-1:0] rdata_a, rdata_b;
   logic            rf_we;
   logic [XLEN-1:0] rf_wdata;
   logic            mem_op;

   mcc_decode #(.XLEN(XLEN)) u_dec (
      .instr (ir_q),
      .dec   (dec),
      .imm   (imm)
   );

   mcc_alu #(.XLEN(XLEN)) u_alu (
      .op (dec.op),
      .a  (opa_q),
      .b  (opb_q),
      .y  (alu_y)
   );

   assign raddr_b = (phase_q == PH_EXEC) ? dec.rd : dec.rs2;

   mcc_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
      .clk     (clk),
      .rst_n   (rst_n),
      .raddr_a (dec.rs1),
      .raddr_b (raddr_b),
      .rdata_a (rdata_a),
      .rdata_b (rdata_b),
      .we      (rf_we),
      .waddr   (dec.rd),
      .wdata   (rf_wdata)
   );

   assign mem_op    = dec.is_load || dec.is_store;
   assign mem_req   = (phase_q == PH_FETCH) || (phase_q == PH_STORE && mem_op);
   assign mem_we    = (phase_q == PH_STORE) && dec.is_store;
   assign mem_addr  = (phase_q == PH_FETCH) ? pc_q : res_q;
   assign mem_wdata = sdata_q;

   assign rf_we    = (phase_q == PH_STORE) &&
                     (dec.is_alu || (dec.is_load && mem_ready));
   assign rf_wdata = dec.is_load ? mem_rdata : res_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q      <= PH_FETCH;
         pc_q         <= RESET_PC;
         ir_q         <= '0;
         opa_q        <= '0;
         opb_q        <= '0;
         res_q        <= '0;
         sdata_q      <= '0;
         illegal_q    <= 1'b0;
         misaligned_q <= 1'b0;
      end else begin
         case (phase_q)
            PH_FETCH: begin
               if (mem_ready) begin
                  ir_q    <= mem_rdata;
                  pc_q    <= pc_q + 32'd4;
                  phase_q <= PH_DECODE;
               end
            end
            PH_DECODE: begin
               if (!dec.legal) begin
                  illegal_q <= 1'b1;
                  phase_q   <= PH_HALT;
               end else begin
                  phase_q <= PH_OPER;
               end
            end
            PH_OPER: begin
               opa_q   <= rdata_a;
               opb_q   <= dec.use_imm ? imm : rdata_b;
               phase_q <= PH_EXEC;
            end
            PH_EXEC: begin
               res_q   <= alu_y;
               sdata_q <= rdata_b;
               if (mem_op && alu_y[1:0] != 2'b00) begin
                  misaligned_q <= 1'b1;
                  phase_q      <= PH_HALT;
               end else begin
                  phase_q <= PH_STORE;
               end
            end
            PH_STORE: begin
               if (!mem_op || mem_ready)
                  phase_q <= PH_FETCH;
            end
            default: phase_q <= PH_HALT;
         endcase
      end
   end

   assign halted     = (phase_q == PH_HALT);
   assign illegal    = illegal_q;
   assign misaligned = misaligned_q;

   AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_FETCH && mem_ready) |=> (pc_q == $past(pc_q) + 32'd4)); // R2
   AST_ZERO_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (dec.rs1 == '0) |-> (rdata_a == '0)); // R3
   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R9
   AST_WDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we && !mem_ready) |=> $stable(mem_wdata)); // R9
   AST_ONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      !(illegal && misaligned)); // R10
   AST_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (mem_addr[1:0] == 2'b00)); // R11
   AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      halted |-> !mem_req); // R13
   AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> halted); // R13

endmodule

// File: tb/mcc_core_test.sv
module mcc_core_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mem_req, mem_we, mem_ready;
   logic [31:0] mem_addr, mem_wdata, mem_rdata;
   logic        halted, illegal, misaligned;

   logic [7:0]  mem_b [512];
   logic        tb_clr = 1'b0;
   logic        tb_we = 1'b0;
   logic [8:0]  tb_addr = '0;
   logic [31:0] tb_data = '0;
   int          stall_cfg = 0;
   int          stall_cnt;
   int          cyc = 0;
   int          log_n;
   logic [31:0] log_addr [64];
   int          log_cyc  [64];
   int          n_chk = 0;
   int          n_fail = 0;

   always #5 clk = ~clk;

   mcc_core uut (
      .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .mem_ready(mem_ready), .halted(halted), .illegal(illegal),
      .misaligned(misaligned)
   );

   // big-endian memory model: byte A is bits 31:24 of the word at A
   logic [8:0] ma;
   assign ma        = {mem_addr[8:2], 2'b00};
   assign mem_rdata = {mem_b[ma], mem_b[ma + 9'd1], mem_b[ma + 9'd2], mem_b[ma + 9'd3]};
   assign mem_ready = (stall_cnt >= stall_cfg);

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (tb_clr) begin
         for (int i = 0; i < 512; i++) mem_b[i] <= 8'h00;
      end else if (tb_we) begin
         mem_b[tb_addr]        <= tb_data[31:24];
         mem_b[tb_addr + 9'd1] <= tb_data[23:16];
         mem_b[tb_addr + 9'd2] <= tb_data[15:8];
         mem_b[tb_addr + 9'd3] <= tb_data[7:0];
      end
      if (!rst_n) begin
         stall_cnt <= 0;
         log_n     <= 0;
      end else if (mem_req) begin
         if (mem_ready) begin
            stall_cnt <= 0;
            if (log_n < 64) begin
               log_addr[log_n] <= mem_addr;
               log_cyc[log_n]  <= cyc;
            end
            log_n <= log_n + 1;
            if (mem_we) begin
               mem_b[ma]        <= mem_wdata[31:24];
               mem_b[ma + 9'd1] <= mem_wdata[23:16];
               mem_b[ma + 9'd2] <= mem_wdata[15:8];
               mem_b[ma + 9'd3] <= mem_wdata[7:0];
            end
         end else begin
            stall_cnt <= stall_cnt + 1;
         end
      end
   end

   initial begin
      #1500000;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk + 1, n_fail + 1);
      $finish;
   end

   function automatic logic [31:0] enc(input logic [1:0] f, input logic [4:0] rd,
                                       input logic [5:0] op3, input logic [4:0] rs1,
                                       input logic i, input logic [12:0] low);
      return {f, rd, op3, rs1, i, low};
   endfunction

   function automatic logic [31:0] sx(input logic [12:0] v);
      return {{19{v[12]}}, v};
   endfunction

   function automatic logic [31:0] model(input logic [5:0] op3, input logic [31:0] a,
                                         input logic [31:0] b);
      case (op3)
         6'h00:   return a + b;
         6'h01:   return a & b;
         6'h02:   return a | b;
         6'h03:   return a ^ b;
         6'h04:   return a - b;
         6'h25:   return a << b[4:0];
         6'h26:   return a >> b[4:0];
         default: return 32'hx;
      endcase
   endfunction

   function automatic logic [31:0] rdw(input int a);
      return {mem_b[a], mem_b[a+1], mem_b[a+2], mem_b[a+3]};
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic begin_load();
      @(negedge clk) rst_n = 1'b0;
      tb_clr = 1'b1;
      @(negedge clk) tb_clr = 1'b0;
   endtask

   task automatic put(input int a, input logic [31:0] w);
      @(negedge clk);
      tb_we = 1'b1; tb_addr = 9'(a); tb_data = w;
      @(negedge clk) tb_we = 1'b0;
   endtask

   task automatic start(input int stall);
      stall_cfg = stall;
      @(negedge clk) rst_n = 1'b1;
      for (int k = 0; k < 3000; k++) begin
         @(negedge clk);
         if (halted) break;
      end
   endtask

   // op3, use_imm, a, b
   localparam int NV = 8;
   localparam logic [32:0] VEC [NV] = '{
      {6'h00, 1'b0, 13'd100,   13'd200},
      {6'h04, 1'b0, 13'd5,     13'd9},
      {6'h01, 1'b1, 13'h00F3,  13'h003C},
      {6'h02, 1'b0, 13'h00F0,  13'h000F},
      {6'h03, 1'b1, 13'h0555,  13'h1FFF},
      {6'h25, 1'b0, 13'd3,     13'd35},
      {6'h26, 1'b1, 13'h1000,  13'd4},
      {6'h00, 1'b1, 13'd4095,  13'h1000}
   };

   initial begin
      // vector table: r1=a, r2=b, r3 = r1 op (r2|imm), store r3 to 0x100, then illegal
      for (int v = 0; v < NV; v++) begin
         logic [5:0]  op3;
         logic        ui;
         logic [12:0] va, vb;
         {op3, ui, va, vb} = VEC[v];
         begin_load();
         put(0,  enc(2'd2, 5'd1, 6'h00, 5'd0, 1'b1, va));
         put(4,  enc(2'd2, 5'd2, 6'h00, 5'd0, 1'b1, vb));
         put(8,  enc(2'd2, 5'd3, op3,   5'd1, ui, ui ? vb : 13'd2));
         put(12, enc(2'd3, 5'd3, 6'h04, 5'd0, 1'b1, 13'h100));
         put(16, 32'h0000_0000);
         if (v == 0) begin
            stall_cfg = 0;
            @(negedge clk) rst_n = 1'b1;
            #1;
            check("R12 req after reset", {29'd0, mem_req, mem_we, halted}, 32'h4);
            check("R12 flags after reset", {30'd0, illegal, misaligned}, 32'h0);
            check("R2 first fetch address", mem_addr, 32'h0);
            for (int k = 0; k < 3000; k++) begin
               @(negedge clk);
               if (halted) break;
            end
            check("R2 fetch 1 address", log_addr[1], 32'h4);
            check("R2 fetch 2 address", log_addr[2], 32'h8);
            check("R2 fetch 3 address", log_addr[3], 32'hC);
            check("R2 fetch after store", log_addr[5], 32'h10);
            check("R1 five cycles per instruction", 32'(log_cyc[1] - log_cyc[0]), 32'd5);
         end else begin
            start(0);
         end
         check($sformatf("R6 R5 vector %0d result", v), rdw(256),
               model(op3, sx(va), sx(vb)));
         check($sformatf("R10 vector %0d ends illegal", v),
               {30'd0, illegal, halted}, 32'h3);
      end

      // R5 R4: the given instruction word
      begin_load();
      put(0, enc(2'd2, 5'd25, 6'h00, 5'd0, 1'b1, 13'd1000));
      put(4, 32'h9406_6168);
      put(8, enc(2'd3, 5'd10, 6'h04, 5'd0, 1'b1, 13'h100));
      start(0);
      check("R5 word 0x94066168", rdw(256), 32'd1360);

      // R3: writes to register 0 are dropped
      begin_load();
      put(256, 32'hDEAD_BEEF);
      put(0, enc(2'd2, 5'd0, 6'h00, 5'd0, 1'b1, 13'd77));
      put(4, enc(2'd3, 5'd0, 6'h04, 5'd0, 1'b1, 13'h100));
      start(0);
      check("R3 register 0 stays zero", rdw(256), 32'h0);

      // R7 R8 R9: reg+reg load, reg+disp store, with and without wait states
      for (int s = 0; s < 2; s++) begin
         begin_load();
         put(288, 32'h1122_3344);
         put(0,  enc(2'd2, 5'd4, 6'h00, 5'd0, 1'b1, 13'h100));
         put(4,  enc(2'd2, 5'd5, 6'h00, 5'd0, 1'b1, 13'h020));
         put(8,  enc(2'd3, 5'd6, 6'h00, 5'd4, 1'b0, 13'd5));
         put(12, enc(2'd3, 5'd6, 6'h04, 5'd4, 1'b1, 13'h040));
         put(16, enc(2'd3, 5'd5, 6'h04, 5'd4, 1'b1, 13'h1FFC));
         start(s * 3);
         check($sformatf("R7 R9 load/store stall %0d", s * 3), rdw(320), 32'h1122_3344);
         check("R8 msb at lowest address", {24'd0, mem_b[320]}, 32'h11);
         check("R8 lsb at highest address", {24'd0, mem_b[323]}, 32'h44);
         check("R7 negative displacement store", rdw(252), 32'h20);
         if (s == 1)
            check("R9 fetch spacing with 3 wait states",
                  32'(log_cyc[1] - log_cyc[0]), 32'd8);
      end

      // R11: misaligned store halts with no access
      begin_load();
      put(256, 32'hCAFE_F00D);
      put(0, enc(2'd2, 5'd1, 6'h00, 5'd0, 1'b1, 13'h102));
      put(4, enc(2'd3, 5'd1, 6'h04, 5'd1, 1'b0, 13'd0));
      start(0);
      check("R11 misaligned flags", {29'd0, misaligned, illegal, halted}, 32'h5);
      check("R11 memory untouched", rdw(256), 32'hCAFE_F00D);
      check("R11 no data access", 32'(log_n), 32'd2);

      // R10 R13: unknown operation code under format 2, then silence
      begin_load();
      put(0, enc(2'd2, 5'd1, 6'h3F, 5'd0, 1'b1, 13'd1));
      start(0);
      check("R10 unknown op3 flags", {29'd0, misaligned, illegal, halted}, 32'h3);
      repeat (20) @(negedge clk);
      check("R13 no request while halted", {31'd0, mem_req}, 32'h0);
      check("R13 no access after halt", 32'(log_n), 32'd1);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule